// File: doc/BRIEF.md
# Circular Pass-Window Phase Selector

This block chooses a sampling phase once a sweep over sixteen candidate clock phases has finished. The sweep result comes in as a pass mask: bit n is set when phase n gave clean reads. A single-cycle start strobe latches the mask. The block then walks the mask one phase per cycle and collects runs of neighbouring passing phases. A run that touches the top phase and a run that touches phase zero count as one window that wraps around. The longest window wins, and the chosen phase sits about three quarters of the way into it.

The result is registered. It appears a fixed number of cycles after the strobe, as a phase index with either a valid flag or an error flag. It stays on the outputs until the next accepted strobe. An empty mask and a mask with every phase passing both produce the error flag.

Top module: `phase_window_pick`

## Requirements
- R1: A run is a maximal group of set mask bits with ascending, adjacent indices. Bits with a clear bit between them belong to different runs, and no run wraps unless R2 applies.
- R2: When bit 0 and bit NPH-1 are both set and the mask is not all ones, the run that ends at NPH-1 and the run that starts at 0 form one window. The window starts at the first index of the high run, and its length is the sum of the two run lengths.
- R3: The window with the greatest length is chosen. On equal lengths, the window that starts at the lowest index wins. A joined window ranks by the start index of its high run.
- R4: With window start S and length L, let k = floor(3·L/4), reduced by 1 when k is not zero. The output phase is (S + k) mod NPH.
- R5: An all-zero mask gives sel_error = 1, sel_valid = 0 and sel_phase = 0.
- R6: An all-ones mask gives sel_error = 1, sel_valid = 0 and sel_phase = 0.
- R7: After reset, sel_valid and sel_error are 0. An accepted start clears both at the next clock edge. The result is then presented exactly NPH+1 clock edges after the accepting edge (17 for NPH = 16).
- R8: A start that arrives while a selection is in progress is ignored. It neither changes the latched mask nor produces another result.
- R9: Once presented, sel_phase, sel_valid and sel_error hold their values until the next accepted start.
- R10: sel_valid and sel_error are never high together, and sel_phase reads 0 whenever sel_error is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to latch pass_mask and begin a selection |
| pass_mask | input | NPH | Bit n set when phase n passed the sweep |
| sel_phase | output | $clog2(NPH) | Selected sampling phase |
| sel_valid | output | 1 | Selected phase is usable |
| sel_error | output | 1 | No usable window (empty or all-ones mask) |

## Verification
The assertions run on every cycle and cover the control and handshake behaviour. They check that an accepted start clears the flags and that the result lands exactly NPH+1 edges later, measured by a counter. They also check that a start during a selection leaves the latched mask untouched, that results hold while idle, that the two flags exclude each other, and that empty and all-ones masks end in error. Which window wins, how the wrapped pair is joined, how ties resolve and the arithmetic for the position inside the window can only be shown by the bench's mask scenarios. Each of these is compared against an independent circular model of the window search.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_PICK = 2'd2
  } pwp_state_e;

  // Offset into a window of length len: floor(3*len/4), less one unless zero.
  function automatic int pwp_offset(input int len);
    int q;
    q = (len * 3) / 4;
    if (q != 0) q = q - 1;
    return q;
  endfunction

  // Phase index reached by stepping from base, modulo the phase count.
  function automatic int pwp_rotate(input int base, input int step, input int n);
    return (base + step) % n;
  endfunction

endpackage

// File: rtl/pwp_ctrl.sv
module pwp_ctrl
  import pwp_pkg::*;
#(
  parameter int NPH = 16,
  localparam int IW = $clog2(NPH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          start_acc,
  output logic          step_en,
  output logic [IW-1:0] step_idx,
  output logic          pick_fire
);

  localparam logic [IW-1:0] LAST = IW'(NPH - 1);

  pwp_state_e    state;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SCAN;
            idx   <= '0;
          end
        end
        ST_SCAN: begin
          if (idx == LAST) state <= ST_PICK;
          else             idx   <= idx + 1'b1;
        end
        ST_PICK: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign start_acc = start && (state == ST_IDLE);
  assign step_en   = (state == ST_SCAN);
  assign step_idx  = idx;
  assign pick_fire = (state == ST_PICK);

endmodule

// File: rtl/pwp_run_scan.sv
module pwp_run_scan
  import pwp_pkg::*;
#(
  parameter int NPH = 16,
  localparam int IW = $clog2(NPH),
  localparam int LW = $clog2(NPH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           step_en,
  input  logic [IW-1:0]  step_idx,
  input  logic [NPH-1:0] mask,
  output logic [IW-1:0]  best_start,
  output logic [LW-1:0]  best_len,
  output logic           run_close,
  output logic           merge_hit
);

  localparam logic [IW-1:0] LAST = IW'(NPH - 1);

  logic [LW-1:0] run_len;
  logic [IW-1:0] run_start;
  logic [LW-1:0] head_len;

  logic          bit_now;
  logic [LW-1:0] ext_len;
  logic [LW-1:0] cl_len;
  logic [IW-1:0] cl_start;
  logic          is_head;
  logic          is_tail;
  logic          wraps;
  logic [LW-1:0] eff_len;

  assign bit_now  = mask[step_idx];
  assign ext_len  = run_len + LW'(1);
  assign is_tail  = bit_now && (step_idx == LAST);
  assign run_close = step_en && (is_tail || (!bit_now && (run_len != '0)));
  assign cl_len   = bit_now ? ext_len : run_len;
  assign cl_start = (bit_now && (run_len == '0)) ? step_idx : run_start;
  assign is_head  = (cl_start == '0);
  assign wraps    = mask[0] && mask[NPH-1] && !(&mask);
  assign merge_hit = run_close && wraps && is_tail;

  always_comb begin
    if (wraps && is_head)      eff_len = '0;
    else if (wraps && is_tail) eff_len = cl_len + head_len;
    else                       eff_len = cl_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len    <= '0;
      run_start  <= '0;
      head_len   <= '0;
      best_len   <= '0;
      best_start <= '0;
    end else if (clear) begin
      run_len    <= '0;
      run_start  <= '0;
      head_len   <= '0;
      best_len   <= '0;
      best_start <= '0;
    end else if (step_en) begin
      run_len <= bit_now ? ext_len : '0;
      if (bit_now) run_start <= cl_start;
      if (run_close && is_head) head_len <= cl_len;
      if (run_close && (eff_len > best_len)) begin
        best_len   <= eff_len;
        best_start <= cl_start;
      end
    end
  end

endmodule

// File: rtl/pwp_pick.sv
module pwp_pick
  import pwp_pkg::*;
#(
  parameter int NPH = 16,
  localparam int IW = $clog2(NPH),
  localparam int LW = $clog2(NPH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          fire,
  input  logic [IW-1:0] best_start,
  input  logic [LW-1:0] best_len,
  output logic [IW-1:0] sel_phase,
  output logic          sel_valid,
  output logic          sel_error
);

  logic          len_bad;
  logic [IW-1:0] ph_next;
  int            off;

  assign len_bad = (best_len == '0) || (int'(best_len) >= NPH);
  assign off     = pwp_offset(int'(best_len));
  assign ph_next = IW'(pwp_rotate(int'(best_start), off, NPH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_phase <= '0;
      sel_valid <= 1'b0;
      sel_error <= 1'b0;
    end else if (clear) begin
      sel_phase <= '0;
      sel_valid <= 1'b0;
      sel_error <= 1'b0;
    end else if (fire) begin
      sel_phase <= len_bad ? '0 : ph_next;
      sel_valid <= !len_bad;
      sel_error <= len_bad;
    end
  end

endmodule

// File: rtl/phase_window_pick.sv
module phase_window_pick
  import pwp_pkg::*;
#(
  parameter int NPH = 16,
  localparam int IW = $clog2(NPH),
  localparam int LW = $clog2(NPH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NPH-1:0] pass_mask,
  output logic [IW-1:0]  sel_phase,
  output logic           sel_valid,
  output logic           sel_error
);

  logic           busy;
  logic           start_acc;
  logic           step_en;
  logic [IW-1:0]  step_idx;
  logic           pick_fire;
  logic [NPH-1:0] mask_q;
  logic [IW-1:0]  best_start;
  logic [LW-1:0]  best_len;
  logic           run_close;
  logic           merge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (start_acc) mask_q <= pass_mask;
  end

  pwp_ctrl #(.NPH(NPH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .start_acc (start_acc),
    .step_en   (step_en),
    .step_idx  (step_idx),
    .pick_fire (pick_fire)
  );

  pwp_run_scan #(.NPH(NPH)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_acc),
    .step_en    (step_en),
    .step_idx   (step_idx),
    .mask       (mask_q),
    .best_start (best_start),
    .best_len   (best_len),
    .run_close  (run_close),
    .merge_hit  (merge_hit)
  );

  pwp_pick #(.NPH(NPH)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_acc),
    .fire       (pick_fire),
    .best_start (best_start),
    .best_len   (best_len),
    .sel_phase  (sel_phase),
    .sel_valid  (sel_valid),
    .sel_error  (sel_error)
  );

endmodule

// File: rtl/pwp_checker.sv
module pwp_checker #(
  parameter int NPH = 16,
  localparam int IW = $clog2(NPH),
  localparam int LAT = NPH + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           start_acc,
  input logic           pick_fire,
  input logic [NPH-1:0] mask_q,
  input logic [IW-1:0]  sel_phase,
  input logic           sel_valid,
  input logic           sel_error
);

  int unsigned since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_acc <= LAT + 1;
    else if (start_acc)         since_acc <= 0;
    else if (since_acc <= LAT)  since_acc <= since_acc + 1;
  end

  // R7: accepted start clears both flags
  a_r7_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (!sel_valid && !sel_error));

  // R7: result rises exactly LAT edges after acceptance
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sel_valid) || $rose(sel_error)) |-> (since_acc == LAT));

  // R8: start while busy leaves the latched mask alone
  a_r8_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mask_q));

  // R9: outputs hold while idle without a start
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sel_phase) && $stable(sel_valid) && $stable(sel_error)));

  // R10: flags exclusive, phase zero on error
  a_r10_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_valid && sel_error));

  a_r10_err_phase: assert property (@(posedge clk) disable iff (!rst_n)
    sel_error |-> (sel_phase == '0));

  // R5: empty mask ends in error
  a_r5_empty_error: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_fire && (mask_q == '0)) |=> sel_error);

  // R6: all-ones mask ends in error
  a_r6_full_error: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_fire && (&mask_q)) |=> sel_error);

endmodule

bind phase_window_pick pwp_checker #(.NPH(NPH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .start_acc (start_acc),
  .pick_fire (pick_fire),
  .mask_q    (mask_q),
  .sel_phase (sel_phase),
  .sel_valid (sel_valid),
  .sel_error (sel_error)
);

// File: tb/phase_window_pick_test.sv
module phase_window_pick_test;

  localparam int N   = 16;
  localparam int LAT = 17;

  typedef struct {
    logic [15:0] mask;
    int          ph;
    bit          err;
    int          t0;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pass_mask = '0;
  logic [3:0]  sel_phase;
  logic        sel_valid;
  logic        sel_error;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  item_t sbq[$];
  bit    prev_res = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phase_window_pick #(.NPH(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pass_mask (pass_mask),
    .sel_phase (sel_phase),
    .sel_valid (sel_valid),
    .sel_error (sel_error)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Circular model: a window starts where a set bit follows a clear one.
  function automatic void model(input logic [15:0] m, output int ph, output bit err);
    int best;
    int bs;
    int n;
    int pos;
    best = 0;
    bs = 0;
    for (int s = 0; s < N; s++) begin
      if (m[s] && !m[(s + N - 1) % N]) begin
        n = 0;
        while (n < N && m[(s + n) % N]) n++;
        if (n > best) begin
          best = n;
          bs = s;
        end
      end
    end
    if (best == 0) begin
      err = 1'b1;
      ph = 0;
    end else begin
      err = 1'b0;
      pos = (best * 3) / 4;
      if (pos > 0) pos--;
      ph = (bs + pos) % N;
    end
  endfunction

  task automatic push_start(input logic [15:0] m, input string tag);
    item_t it;
    model(m, it.ph, it.err);
    it.mask = m;
    it.t0 = cyc;
    it.tag = tag;
    sbq.push_back(it);
    pass_mask = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input logic [15:0] m, input string tag);
    push_start(m, tag);
    repeat (LAT + 3) @(negedge clk);
  endtask

  // Monitor: pop the scoreboard when a result rises
  always @(negedge clk) begin
    bit now_res;
    item_t it;
    if (rst_n) begin
      now_res = sel_valid || sel_error;
      if (now_res && !prev_res) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R8", "unexpected result", 1, 0);
        end else begin
          it = sbq.pop_front();
          check(sel_phase == it.ph[3:0], it.tag, $sformatf("phase mask %h", it.mask),
                int'(sel_phase), it.ph);
          check(sel_error == it.err, it.tag, $sformatf("error mask %h", it.mask),
                int'(sel_error), int'(it.err));
          check(sel_valid == !it.err, "R10", $sformatf("valid mask %h", it.mask),
                int'(sel_valid), int'(!it.err));
          check((cyc - it.t0) == LAT + 1, "R7", "latency", cyc - it.t0 - 1, LAT);
        end
      end
      prev_res = now_res;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!sel_valid && !sel_error && sel_phase == 0, "R7", "reset state",
          int'({sel_valid, sel_error, sel_phase}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_case(16'h0001, "R4");
    run_case(16'h0002, "R1");
    run_case(16'h00F0, "R4");
    run_case(16'h0F0F, "R3");
    run_case(16'h8001, "R2");
    run_case(16'hC007, "R2");
    run_case(16'hC0E1, "R3");
    run_case(16'hE00F, "R2");
    run_case(16'h7FFE, "R1");
    run_case(16'h7FFF, "R4");
    run_case(16'hFFFE, "R1");
    run_case(16'hFFF7, "R2");
    run_case(16'h5555, "R1");
    run_case(16'hAAAA, "R3");
    run_case(16'h0000, "R5");
    run_case(16'hFFFF, "R6");

    // R8: second start during the scan must be ignored
    push_start(16'h00F0, "R8");
    repeat (4) @(negedge clk);
    pass_mask = 16'h8001;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    check(sel_valid && sel_phase == 4'd6, "R8", "result after busy start",
          int'(sel_phase), 6);

    // R9: result holds while idle even as the mask input moves
    pass_mask = 16'h0003;
    repeat (12) @(negedge clk);
    check(sel_valid && !sel_error && sel_phase == 4'd6, "R9", "held result",
          int'(sel_phase), 6);

    // R7: flags drop one edge after an accepted start
    pass_mask = 16'h0700;
    start = 1'b1;
    sbq.push_back('{mask: 16'h0700, ph: 9, err: 1'b0, t0: cyc, tag: "R4"});
    @(negedge clk);
    start = 1'b0;
    check(!sel_valid && !sel_error, "R7", "flags cleared on start",
          int'({sel_valid, sel_error}), 0);
    repeat (LAT + 3) @(negedge clk);

    check(sbq.size() == 0, "R8", "scoreboard drained", sbq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule